// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between the highest-pending output of an interrupt distributor and a single processor. Each cycle it sees one candidate: a valid flag, a 10-bit ID, an 8-bit priority and the number of the CPU that requested it. Lower priority values are more urgent. The block raises the processor interrupt line when three conditions hold: signalling is enabled, the candidate beats the software priority mask, and the candidate beats the current running priority.

Software talks to the block over a simple single-cycle register bus. Read data is combinational.

- Reading the acknowledge register claims the candidate. The read pushes the candidate's priority onto a small active-priority stack and sends an acknowledge strobe to the distributor.
- Writing the claimed ID back to the end-of-interrupt register pops the stack and sends an EOI strobe. The running priority then returns to the level of the interrupt that was interrupted.
- If nothing qualifies, an acknowledge read returns the spurious ID 1023 and changes nothing.

The interrupt line is held in a two-state machine with these transitions:

- `SIG_IDLE` goes to `SIG_RAISED` when the candidate qualifies and is not being acknowledged in the same cycle.
- `SIG_RAISED` goes back to `SIG_IDLE` when the candidate stops qualifying or is acknowledged.
- Each state otherwise holds.

The line is the registered state, so it follows the qualify condition one cycle later.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the interrupt line and both strobes are low. Control reads 0, mask reads 0, binary point reads 0, and running priority (word 0x14) reads 0xFF.
- R2: One cycle after a qualifying candidate, the line is high. A candidate qualifies when all of the following hold: control bit 0 is set, the candidate is valid, its priority is strictly below the mask, its priority is strictly below the running priority, and the stack is not full. Otherwise the line is low one cycle later.
- R3: The mask register (word 0x04) keeps only bits [7:4] of the written value and reads back with bits [3:0] zero. A priority equal to the mask does not qualify.
- R4: The binary point register (word 0x08) stores bits [2:0] and reads back those bits. Its value never changes qualification.
- R5: A qualifying acknowledge read (word 0x0C) returns the ID in bits [9:0]. For IDs below 16 it also returns the requesting CPU in bits [12:10]; for all other IDs those bits read 0.
- R6: A non-qualifying acknowledge read returns 1023. It raises no strobe and does not change the running priority.
- R7: A qualifying acknowledge read pushes the candidate's priority, which then becomes the running priority. In the next cycle the acknowledge strobe pulses for one cycle with the claimed ID.
- R8: Writing to the EOI register (word 0x10) a value whose bits [9:0] equal the most recently claimed, still-active ID pops the stack. The running priority returns to the previous level, or to 0xFF when the stack is empty. In the next cycle the EOI strobe pulses with that ID.
- R9: An EOI write whose ID is not the most recent active one, or that arrives when the stack is empty, is ignored. No strobe fires and the running priority is unchanged.
- R10: With four interrupts active the stack is full. Nothing qualifies, the line stays low and an acknowledge read returns 1023.
- R11: The highest-pending register (word 0x18) returns the candidate's ID and CPU field (same layout as R5) whenever the candidate is valid, regardless of mask or enable; with no valid candidate it returns 1023. Writes to words 0x14 and 0x18 have no effect.
- R12: After an acknowledge, the line is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_valid | input | 1 | A candidate is pending at the distributor |
| hp_id | input | 10 | Candidate interrupt ID |
| hp_prio | input | 8 | Candidate priority (lower is more urgent) |
| hp_src_cpu | input | 3 | Requesting CPU for software-generated IDs |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; the word is selected by bits [7:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_stb | output | 1 | One-cycle acknowledge strobe to the distributor |
| ack_id | output | 10 | ID that was acknowledged |
| eoi_stb | output | 1 | One-cycle end-of-interrupt strobe to the distributor |
| eoi_id | output | 10 | ID that was completed |

## Verification
The bench targets the following corner cases.

- **Priority comparisons.** A priority equal to the mask or to the running priority must not qualify; a design using a non-strict comparison would raise the line and hand out an interrupt that cannot preempt.
- **Nesting.** Nested acknowledges followed by EOIs in reverse order check that the running priority returns to each earlier level; a design that cleared the running priority on any EOI would let lower-priority work preempt the outer handler.
- **Ignored EOIs.** EOIs for a buried or unknown ID, and EOIs on an empty stack, must be ignored; a design that popped anyway would lose track of active interrupts.
- **Full stack and acknowledge side effects.** The bench fills the stack to check that a fifth claim is refused. It also checks that a spurious acknowledge read raises no strobe, and that the line drops the cycle after an acknowledge rather than lingering and causing a second claim.

// File: rtl/cif_pkg.sv
package cif_pkg;

    // Register word index (byte address bits [7:2]); offsets are software-visible
    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_PMASK  = 3'd1,
        REG_BPT    = 3'd2,
        REG_ACK    = 3'd3,
        REG_EOI    = 3'd4,
        REG_RUN    = 3'd5,
        REG_HIPEND = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    // Interrupt line state machine
    typedef enum logic {
        SIG_IDLE   = 1'b0,
        SIG_RAISED = 1'b1
    } sig_state_e;

    function automatic reg_sel_e word_decode(input logic [5:0] word);
        reg_sel_e sel;
        case (word)
            6'd0:    sel = REG_CTRL;
            6'd1:    sel = REG_PMASK;
            6'd2:    sel = REG_BPT;
            6'd3:    sel = REG_ACK;
            6'd4:    sel = REG_EOI;
            6'd5:    sel = REG_RUN;
            6'd6:    sel = REG_HIPEND;
            default: sel = REG_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/cif_prio_stack.sv
module cif_prio_stack #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [ID_W-1:0]   top_id,
    output logic [PRIO_W-1:0] top_prio,
    output logic              empty,
    output logic              full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  count_q;
    logic [ID_W-1:0]   slot_id_arr   [DEPTH];
    logic [PRIO_W-1:0] slot_prio_arr [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (push && !full) begin
            count_q <= count_q + CNT_W'(1);
        end else if (pop && !empty) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ID_W-1:0]   id_q;
        logic [PRIO_W-1:0] prio_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                id_q   <= '0;
                prio_q <= '0;
            end else if (push && (count_q == CNT_W'(g))) begin
                id_q   <= push_id;
                prio_q <= push_prio;
            end
        end
        assign slot_id_arr[g]   = id_q;
        assign slot_prio_arr[g] = prio_q;
    end

    always_comb begin
        top_id   = '0;
        top_prio = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (count_q == CNT_W'(i + 1)) begin
                top_id   = slot_id_arr[i];
                top_prio = slot_prio_arr[i];
            end
        end
    end

    assign empty = (count_q == '0);
    assign full  = (count_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9
    AST_PUSH_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_prio == $past(push_prio))); // R7

endmodule

// File: rtl/cif_regs.sv
module cif_regs
    import cif_pkg::*;
#(
    parameter int ID_W      = 10,
    parameter int PRIO_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int MASK_BITS = 4,
    parameter int BPT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] ack_word,
    input  logic [DATA_W-1:0] hp_word,
    input  logic [PRIO_W-1:0] run_prio,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sig_en,
    output logic [PRIO_W-1:0] prio_mask,
    output logic              rd_ack,
    output logic              wr_eoi,
    output logic [ID_W-1:0]   eoi_val
);
    localparam int LOW_BITS = PRIO_W - MASK_BITS;

    reg_sel_e           sel;
    logic               en_q;
    logic [MASK_BITS-1:0] mask_hi_q;
    logic [BPT_W-1:0]   bpt_q;
    logic               wr_any;

    assign sel    = word_decode(bus_addr[ADDR_W-1:2]);
    assign wr_any = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            mask_hi_q <= '0;
            bpt_q     <= '0;
        end else if (wr_any) begin
            unique case (sel)
                REG_CTRL:  en_q      <= bus_wdata[0];
                REG_PMASK: mask_hi_q <= bus_wdata[PRIO_W-1:LOW_BITS];
                REG_BPT:   bpt_q     <= bus_wdata[BPT_W-1:0];
                default:   ;
            endcase
        end
    end

    assign sig_en    = en_q;
    assign prio_mask = {mask_hi_q, {LOW_BITS{1'b0}}};
    assign rd_ack    = bus_sel && !bus_wr && (sel == REG_ACK);
    assign wr_eoi    = wr_any && (sel == REG_EOI);
    assign eoi_val   = bus_wdata[ID_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                REG_CTRL:   bus_rdata = DATA_W'(en_q);
                REG_PMASK:  bus_rdata = DATA_W'(prio_mask);
                REG_BPT:    bus_rdata = DATA_W'(bpt_q);
                REG_ACK:    bus_rdata = ack_word;
                REG_RUN:    bus_rdata = DATA_W'(run_prio);
                REG_HIPEND: bus_rdata = hp_word;
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_BPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && sel == REG_BPT) |=> (bpt_q == $past(bpt_q))); // R4

endmodule

// File: rtl/cif_signal_fsm.sv
module cif_signal_fsm
    import cif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic ack_take,
    output logic irq_o
);
    sig_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SIG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SIG_IDLE:   if (qual && !ack_take)   state_d = SIG_RAISED;
            SIG_RAISED: if (ack_take || !qual)   state_d = SIG_IDLE;
            default:    state_d = SIG_IDLE;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            SIG_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> !irq_o); // R12
    AST_RAISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(qual)); // R2

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface #(
    parameter int ID_W        = 10,
    parameter int PRIO_W      = 8,
    parameter int CPU_W       = 3,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int STACK_DEPTH = 4,
    parameter int SGI_LIMIT   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_valid,
    input  logic [ID_W-1:0]   hp_id,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic [CPU_W-1:0]  hp_src_cpu,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              ack_stb,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_stb,
    output logic [ID_W-1:0]   eoi_id
);
    localparam logic [ID_W-1:0] SPUR_ID = '1;

    logic              sig_en;
    logic [PRIO_W-1:0] prio_mask;
    logic              rd_ack, wr_eoi;
    logic [ID_W-1:0]   eoi_val;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] run_prio;
    logic              stk_empty, stk_full;
    logic              qual, ack_take, eoi_hit;
    logic [CPU_W-1:0]  cpu_field;
    logic [DATA_W-1:0] ack_word, hp_word;
    logic              ack_stb_q, eoi_stb_q;
    logic [ID_W-1:0]   ack_id_q, eoi_id_q;

    assign qual = sig_en && hp_valid && (hp_prio < prio_mask)
                  && (hp_prio < run_prio) && !stk_full;
    assign cpu_field = (hp_id < ID_W'(SGI_LIMIT)) ? hp_src_cpu : '0;
    assign ack_word  = qual     ? DATA_W'({cpu_field, hp_id}) : DATA_W'(SPUR_ID);
    assign hp_word   = hp_valid ? DATA_W'({cpu_field, hp_id}) : DATA_W'(SPUR_ID);
    assign ack_take  = rd_ack && qual;
    assign eoi_hit   = wr_eoi && !stk_empty && (eoi_val == top_id);

    cif_regs #(
        .ID_W(ID_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .MASK_BITS(4), .BPT_W(3)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ack_word(ack_word), .hp_word(hp_word),
        .run_prio(run_prio), .bus_rdata(bus_rdata), .sig_en(sig_en),
        .prio_mask(prio_mask), .rd_ack(rd_ack), .wr_eoi(wr_eoi),
        .eoi_val(eoi_val)
    );

    cif_prio_stack #(
        .ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)
    ) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(ack_take), .push_id(hp_id), .push_prio(hp_prio),
        .pop(eoi_hit), .top_id(top_id), .top_prio(run_prio),
        .empty(stk_empty), .full(stk_full)
    );

    cif_signal_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .qual(qual), .ack_take(ack_take),
        .irq_o(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_stb_q <= 1'b0;
            ack_id_q  <= '0;
            eoi_stb_q <= 1'b0;
            eoi_id_q  <= '0;
        end else begin
            ack_stb_q <= ack_take;
            eoi_stb_q <= eoi_hit;
            if (ack_take) ack_id_q <= hp_id;
            if (eoi_hit)  eoi_id_q <= eoi_val;
        end
    end

    assign ack_stb = ack_stb_q;
    assign ack_id  = ack_id_q;
    assign eoi_stb = eoi_stb_q;
    assign eoi_id  = eoi_id_q;

    AST_SPUR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !qual) |=> !ack_stb); // R6
    AST_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eoi && !eoi_hit) |=> (!eoi_stb && $stable(run_prio))); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_stb && eoi_stb)); // R7

endmodule

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_valid = 1'b0;
    logic [9:0]  hp_id = '0;
    logic [7:0]  hp_prio = '0;
    logic [2:0]  hp_src_cpu = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, ack_stb, eoi_stb;
    logic [9:0]  ack_id, eoi_id;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cpu_irq_iface u_dut (
        .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id),
        .hp_prio(hp_prio), .hp_src_cpu(hp_src_cpu), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .ack_stb(ack_stb),
        .ack_id(ack_id), .eoi_stb(eoi_stb), .eoi_id(eoi_id)
    );

    // ---------------- behavioural reference model ----------------
    int m_en, m_mask, m_bpt;
    int q_id[$];
    int q_pr[$];
    bit m_irq, m_ack_stb, m_eoi_stb;
    int m_ack_id, m_eoi_id;

    function automatic int m_run();
        return (q_pr.size() > 0) ? q_pr[$] : 255;
    endfunction

    function automatic bit m_qual();
        return (m_en != 0) && hp_valid && (int'(hp_prio) < m_mask)
               && (int'(hp_prio) < m_run()) && (q_pr.size() < 4);
    endfunction

    function automatic int m_word();
        int c;
        c = (hp_id < 16) ? int'(hp_src_cpu) : 0;
        return (c << 10) | int'(hp_id);
    endfunction

    function automatic int m_rdata(input int addr);
        case (addr)
            8'h00: return m_en;
            8'h04: return m_mask;
            8'h08: return m_bpt;
            8'h0C: return m_qual() ? m_word() : 1023;
            8'h14: return m_run();
            8'h18: return hp_valid ? m_word() : 1023;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_mask = 0; m_bpt = 0;
            q_id.delete(); q_pr.delete();
            m_irq = 0; m_ack_stb = 0; m_eoi_stb = 0; m_ack_id = 0; m_eoi_id = 0;
        end else begin
            bit q, take, hit;
            int wd;
            q    = m_qual();
            take = bus_sel && !bus_wr && (bus_addr == 8'h0C) && q;
            wd   = int'(bus_wdata);
            hit  = bus_sel && bus_wr && (bus_addr == 8'h10) && (q_id.size() > 0)
                   && ((wd & 1023) == q_id[$]);
            m_irq     = q && !take;
            m_ack_stb = take;
            m_eoi_stb = hit;
            if (take) begin
                m_ack_id = int'(hp_id);
                q_id.push_back(int'(hp_id));
                q_pr.push_back(int'(hp_prio));
            end
            if (hit) begin
                m_eoi_id = wd & 1023;
                void'(q_id.pop_back());
                void'(q_pr.pop_back());
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    8'h00: m_en   = wd & 1;
                    8'h04: m_mask = wd & 8'hF0;
                    8'h08: m_bpt  = wd & 7;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every clock, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 irq line", int'(irq_o), int'(m_irq));
            chk("R7 ack strobe", int'(ack_stb), int'(m_ack_stb));
            if (m_ack_stb) chk("R7 ack id", int'(ack_id), m_ack_id);
            chk("R8 eoi strobe", int'(eoi_stb), int'(m_eoi_stb));
            if (m_eoi_stb) chk("R8 eoi id", int'(eoi_id), m_eoi_id);
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    8'h0C:   chk(m_qual() ? "R5 ack read" : "R6 spurious read",
                                 int'(bus_rdata), m_rdata(8'h0C));
                    8'h04:   chk("R3 mask read", int'(bus_rdata), m_rdata(8'h04));
                    8'h08:   chk("R4 binary point read", int'(bus_rdata), m_rdata(8'h08));
                    8'h14:   chk("R8 running read", int'(bus_rdata), m_rdata(8'h14));
                    8'h18:   chk("R11 pending read", int'(bus_rdata), m_rdata(8'h18));
                    default: chk("R1 register read", int'(bus_rdata), m_rdata(int'(bus_addr)));
                endcase
            end
        end
    end

    // ---------------- stimulus tasks (start/end at posedge+2) ----------------
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input int addr, input int data);
        bus_sel = 1; bus_wr = 1; bus_addr = addr[7:0]; bus_wdata = data;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int addr, output int data);
        bus_sel = 1; bus_wr = 0; bus_addr = addr[7:0];
        @(negedge clk); data = int'(bus_rdata);
        step();
        bus_sel = 0;
    endtask

    task automatic cand(input bit v, input int id, input int pr, input int cpu);
        hp_valid = v; hp_id = id[9:0]; hp_prio = pr[7:0]; hp_src_cpu = cpu[2:0];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        int d;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        step();
        // R1 reset state
        chk("R1 irq low", int'(irq_o), 0);
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h04, d); chk("R1 mask", d, 0);
        rd(8'h08, d); chk("R1 binary point", d, 0);
        rd(8'h14, d); chk("R1 running", d, 8'hFF);

        // disabled: nothing signalled, spurious ack
        cand(1, 40, 8'h80, 0);
        wr(8'h04, 8'hF0);
        step();
        chk("R2 disabled no irq", int'(irq_o), 0);
        rd(8'h0C, d); chk("R6 spurious when disabled", d, 1023);
        step(); chk("R6 no strobe", int'(ack_stb), 0);
        wr(8'h00, 1);
        step();
        chk("R2 irq raised", int'(irq_o), 1);
        rd(8'h0C, d); chk("R5 ack id 40", d, 40);
        chk("R12 irq low after ack", int'(irq_o), 0);
        rd(8'h14, d); chk("R7 running 0x80", d, 8'h80);

        // nested software interrupt with cpu field
        cand(1, 5, 8'h40, 3);
        step();
        chk("R2 nested irq", int'(irq_o), 1);
        rd(8'h0C, d); chk("R5 sgi with cpu", d, (3 << 10) | 5);
        rd(8'h14, d); chk("R7 running 0x40", d, 8'h40);
        // equal priority does not beat running
        cand(1, 77, 8'h40, 0);
        step(); step();
        chk("R2 equal to running no irq", int'(irq_o), 0);

        // EOI handling
        wr(8'h10, 40);
        rd(8'h14, d); chk("R9 wrong eoi ignored", d, 8'h40);
        wr(8'h10, (3 << 10) | 5);
        rd(8'h14, d); chk("R8 restored 0x80", d, 8'h80);
        wr(8'h10, 40);
        rd(8'h14, d); chk("R8 empty 0xFF", d, 8'hFF);
        wr(8'h10, 40);
        chk("R9 empty eoi no strobe", int'(eoi_stb), 0);

        // mask granularity
        cand(0, 0, 0, 0);
        wr(8'h04, 8'h8F);
        rd(8'h04, d); chk("R3 mask low nibble dropped", d, 8'h80);
        cand(1, 60, 8'h80, 0);
        step(); step();
        chk("R3 equal to mask no irq", int'(irq_o), 0);
        cand(1, 60, 8'h7F, 0);
        step(); step();
        chk("R3 below mask irq", int'(irq_o), 1);

        // binary point has no effect
        wr(8'h08, 8'hFF);
        rd(8'h08, d); chk("R4 bpt bits", d, 7);
        chk("R4 bpt no effect", int'(irq_o), 1);

        // fill the stack
        wr(8'h04, 8'hFF);
        for (int k = 0; k < 4; k++) begin
            cand(1, 100 + k, 8'h70 - 16 * k, 0);
            step();
            rd(8'h0C, d); chk("R7 fill ack", d, 100 + k);
        end
        cand(1, 200, 8'h10, 0);
        step(); step();
        chk("R10 full no irq", int'(irq_o), 0);
        rd(8'h0C, d); chk("R10 full spurious", d, 1023);
        for (int k = 3; k >= 0; k--) wr(8'h10, 100 + k);
        rd(8'h14, d); chk("R8 all popped", d, 8'hFF);

        // pending register and read-only words
        cand(0, 0, 0, 0);
        rd(8'h18, d); chk("R11 no pending", d, 1023);
        cand(1, 12, 8'hFF, 2);
        rd(8'h18, d); chk("R11 pending blocked by mask", d, (2 << 10) | 12);
        wr(8'h14, 8'h00);
        wr(8'h18, 8'h00);
        rd(8'h14, d); chk("R11 running not writable", d, 8'hFF);

        // randomized traffic, checked by the model every clock
        for (int it = 0; it < 600; it++) begin
            int op;
            cand($urandom_range(3, 0) != 0, $urandom_range(63, 0),
                 $urandom_range(255, 0), $urandom_range(7, 0));
            op = $urandom_range(9, 0);
            case (op)
                0, 1, 2: rd(8'h0C, d);
                3, 4: begin
                    if (q_id.size() > 0 && $urandom_range(3, 0) != 0) wr(8'h10, q_id[$]);
                    else wr(8'h10, $urandom_range(63, 0));
                end
                5: wr(8'h04, $urandom_range(255, 0));
                6: wr(8'h00, $urandom_range(4, 0) != 0);
                7: rd(4 * $urandom_range(7, 0), d);
                default: step();
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule